// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator, data-carrier-detect) and presents them to the CPU as one 8-bit status byte. The upper nibble shows the present asserted state of each line, which is the inverse of the pin level. The lower nibble holds sticky change flags. A CPU read clears these flags. Each pin first passes through a synchronizer chain. In loopback mode the four levels are taken from bits of a handshake control word instead of from the pins.

Each change flag is kept by its own two-state machine. `FLG_IDLE` moves to `FLG_HELD` on a qualifying event (the "capture" transition). `FLG_HELD` moves back to `FLG_IDLE` on a read strobe only when no new event arrives in the same cycle (the "release" transition). Otherwise the machine stays where it is. The ring-indicator channel counts only the pin going from low to high as an event. The other three channels count a change in either direction. A modem-status interrupt request is the OR of the four flags, gated by an enable input.

Top module: `modem_status_tracker`

## Requirements
- R1: With all pins high and loopback off, reset leaves `rd_data` at 0x00 and `irq` low.
- R2: With loopback off, `rd_data` bits 4, 5, 6 and 7 show the inverse of the CTS#, DSR#, RI# and DCD# pins. A pin change made before a rising edge appears after the third rising edge (two synchronizer stages plus the level register).
- R3: With loopback on, the pins are ignored. Bit 4 takes `hs_ctrl[1]`, bit 5 takes `hs_ctrl[0]`, bit 6 takes `hs_ctrl[2]` and bit 7 takes `hs_ctrl[3]`, one rising edge after the control value is applied.
- R4: Bits 0, 1 and 3 set when the selected CTS, DSR or DCD level (bit 4, 5 or 7) changes in either direction.
- R5: Bit 2 sets only when the RI# pin goes from low to high, which is when bit 6 goes from 1 to 0. A high-to-low move of RI# leaves bit 2 clear.
- R6: A set flag in bits 0 to 3 stays set until a read.
- R7: While `rd_stb` is high, `rd_data` returns the flags before the clear. The rising edge that ends the strobe cycle clears bits 0 to 3.
- R8: A change that reaches the level register on the same edge as a read leaves its flag set after the read.
- R9: Entering or leaving loopback sets a flag only for a channel whose selected level differs between the two sources.
- R10: `irq` is high exactly when `irq_en` is high and at least one of bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_ri_n | input | 1 | Ring indicator pin, active low |
| pin_dcd_n | input | 1 | Data-carrier-detect pin, active low |
| loop_en | input | 1 | Loopback select; levels come from `hs_ctrl` |
| hs_ctrl | input | 4 | Handshake control bits used as sources in loopback |
| rd_stb | input | 1 | Status register read strobe |
| irq_en | input | 1 | Modem-status interrupt enable |
| rd_data | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The risky overlap is a read strobe and a flag capture landing on the same clock edge. In that case the release transition must lose to the capture transition. The bench sets up this overlap by moving a CTS# pin and timing the strobe so that it sits on the edge where the synchronized change reaches the level register. A second flag that was already pending is set up in the same test. The bench then expects the returned byte to show only the old flag, and the byte after the read to show only the new flag. Switching loopback on and off with matching and with differing control values is judged the same way, to catch flags raised by the source switch alone.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int CHANNELS = 4;

    typedef enum logic {
        EDGE_ANY,
        EDGE_FALL
    } edge_mode_e;

    typedef enum logic {
        FLG_IDLE,
        FLG_HELD
    } flag_state_e;

    // channel order: 0 CTS, 1 DSR, 2 RI, 3 DCD
    function automatic int loop_src_idx(input int ch);
        case (ch)
            0:       return 1;
            1:       return 0;
            default: return ch;
        endcase
    endfunction

    function automatic edge_mode_e chan_mode(input int ch);
        return (ch == 2) ? EDGE_FALL : EDGE_ANY;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/msd_delta_flag.sv
module msd_delta_flag
    import msd_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_ANY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_now,
    input  logic lvl_prev,
    input  logic rd_clr,
    output logic flag
);

    flag_state_e state_q, state_d;
    logic        evt;

    generate
        if (MODE == EDGE_FALL) begin : g_fall
            assign evt = lvl_prev & ~lvl_now;
        end else begin : g_any
            assign evt = lvl_prev ^ lvl_now;
        end
    endgenerate

    // next-state: capture beats release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (evt)              state_d = FLG_HELD;
            FLG_HELD: if (rd_clr && !evt)   state_d = FLG_IDLE;
            default:                        state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLG_HELD);
    end

    // R6
    hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !rd_clr) |=> flag);

    // R8
    capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R7
    release_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !evt) |=> !flag);

endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_cts_n,
    input  logic       pin_dsr_n,
    input  logic       pin_ri_n,
    input  logic       pin_dcd_n,
    input  logic       loop_en,
    input  logic [3:0] hs_ctrl,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] rd_data,
    output logic       irq
);

    localparam int LVL_LSB = CHANNELS;

    logic [CHANNELS-1:0] pin_vec_n;
    logic [CHANNELS-1:0] sync_n;
    logic [CHANNELS-1:0] lvl_sel;
    logic [CHANNELS-1:0] lvl_q;
    logic [CHANNELS-1:0] flags;

    assign pin_vec_n = {pin_dcd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

    msd_sync #(
        .WIDTH   (CHANNELS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_vec_n),
        .dout  (sync_n)
    );

    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
            localparam int SRC = loop_src_idx(ch);

            assign lvl_sel[ch] = loop_en ? hs_ctrl[SRC] : ~sync_n[ch];

            msd_delta_flag #(
                .MODE (chan_mode(ch))
            ) u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_now  (lvl_sel[ch]),
                .lvl_prev (lvl_q[ch]),
                .rd_clr   (rd_stb),
                .flag     (flags[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_sel;
    end

    always_comb begin
        rd_data = {lvl_q, flags};
        irq     = irq_en & (|flags);
    end

    // R5
    ri_trailing_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[2]) |-> $fell(rd_data[LVL_LSB+2]));

    // R4
    cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> !$stable(rd_data[LVL_LSB]));

    // R3
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (rd_data[7:4] == {$past(hs_ctrl[3]), $past(hs_ctrl[2]),
                                       $past(hs_ctrl[0]), $past(hs_ctrl[1])}));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

endmodule

// File: tb/test_modem_status_tracker.sv
module test_modem_status_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_ri_n = 1'b1, pin_dcd_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] hs_ctrl = 4'h0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    modem_status_tracker i_modem_status_tracker (
        .clk(clk), .rst_n(rst_n),
        .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_ri_n(pin_ri_n), .pin_dcd_n(pin_dcd_n),
        .loop_en(loop_en), .hs_ctrl(hs_ctrl),
        .rd_stb(rd_stb), .irq_en(irq_en),
        .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // pins given as asserted-level nibble {dcd,ri,dsr,cts}
    task automatic set_lvl(input logic [3:0] lv);
        pin_cts_n = ~lv[0];
        pin_dsr_n = ~lv[1];
        pin_ri_n  = ~lv[2];
        pin_dcd_n = ~lv[3];
    endtask

    task automatic do_read(output logic [7:0] got);
        rd_stb = 1'b1;
        got = rd_data;
        tick(1);
        rd_stb = 1'b0;
    endtask

    function automatic logic [3:0] loop_map(input logic [3:0] c);
        return {c[3], c[2], c[0], c[1]};
    endfunction

    function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] f;
        f = a ^ b;
        f[2] = a[2] & ~b[2];
        return f;
    endfunction

    initial begin
        logic [7:0] got;
        logic [3:0] fl;
        @(negedge clk);
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1
        chk("R1 reset data", rd_data, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        // R2 latency: not visible after two edges, visible after three
        set_lvl(4'b0001);
        tick(2);
        chk("R2 latency early", rd_data, 8'h00);
        tick(1);
        chk("R2 latency", rd_data, 8'h11);
        do_read(got);
        set_lvl(4'b0000);
        tick(4);
        do_read(got);

        // R2 R4 R5 R6 R7 R10 sweep over all pin pattern pairs
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                irq_en = a[0] ^ b[1];
                set_lvl(a[3:0]);
                tick(4);
                do_read(got);
                set_lvl(b[3:0]);
                tick(3);
                fl = exp_flags(a[3:0], b[3:0]);
                chk("R2 R4 R5 pin sweep", rd_data, {b[3:0], fl});
                chk("R10 irq", {7'd0, irq}, {7'd0, irq_en & (|fl)});
                tick(2);
                chk("R6 sticky", rd_data, {b[3:0], fl});
                do_read(got);
                chk("R7 read value", got, {b[3:0], fl});
                chk("R7 cleared", rd_data, {b[3:0], 4'h0});
            end
        end
        irq_en = 1'b1;

        // R8 same-edge read and change
        set_lvl(4'b0000);
        tick(4);
        do_read(got);
        set_lvl(4'b0010);
        tick(3);
        pin_cts_n = 1'b0;
        tick(2);
        rd_stb = 1'b1;
        got = rd_data;
        tick(1);
        rd_stb = 1'b0;
        chk("R8 read returns old flag", got, 8'h22);
        chk("R8 new flag survives", rd_data, 8'h31);
        set_lvl(4'b0000);
        tick(4);
        do_read(got);
        do_read(got);

        // R9 loopback entry with matching source
        hs_ctrl = 4'h0;
        loop_en = 1'b1;
        tick(1);
        chk("R9 enter matching", rd_data, 8'h00);
        hs_ctrl = 4'b0010;
        tick(1);
        chk("R3 R4 loop cts", rd_data, 8'h11);
        do_read(got);

        // R3 loopback sweep, pins moved to prove they are ignored
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                hs_ctrl = a[3:0];
                set_lvl(a[3:0] ^ 4'b0101);
                tick(1);
                do_read(got);
                hs_ctrl = b[3:0];
                set_lvl(b[3:0] ^ 4'b1010);
                tick(1);
                chk("R3 loop sweep", rd_data,
                    {loop_map(b[3:0]), exp_flags(loop_map(a[3:0]), loop_map(b[3:0]))});
                tick(3);
                chk("R3 pins ignored", rd_data,
                    {loop_map(b[3:0]), exp_flags(loop_map(a[3:0]), loop_map(b[3:0]))});
                do_read(got);
            end
        end

        // R9 leave loopback with matching source
        hs_ctrl = 4'h0;
        set_lvl(4'b0000);
        tick(4);
        do_read(got);
        loop_en = 1'b0;
        tick(1);
        chk("R9 leave matching", rd_data, 8'h00);

        // R9 enter and leave with differing source
        hs_ctrl = 4'hF;
        loop_en = 1'b1;
        tick(1);
        chk("R9 enter differing", rd_data, 8'hFB);
        do_read(got);
        loop_en = 1'b0;
        tick(1);
        chk("R9 leave differing", rd_data, 8'h0F);
        chk("R10 irq on", {7'd0, irq}, 8'h01);
        irq_en = 1'b0;
        tick(1);
        chk("R10 irq gated", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule